// File: doc/BRIEF.md
# Process Interface Mode Controller

This block chooses the operating mode of a 32-pin process-data interface in a fieldbus slave controller and decides which pins may leave high impedance. It sits between the engine that loads the non-volatile configuration and the pad ring. When the loader reports a successful load, the block captures an 8-bit interface-select code. It decodes that code into one mode: off, general digital I/O, serial slave, bridge port, an asynchronous or synchronous microcontroller bus of 8 or 16 bits, one of five fixed input/output splits of the pins, or an on-chip bus. It then raises one select strobe towards the matching protocol engine. The protocol engines themselves are outside this block.

A strap input picks between two variants. In the load-dependent variant, every pin, the sync/latch lines and the load-done indicator stay undriven until the first successful load. In the power-on-configured variant, the block takes its code from a separate strap code bus and becomes active one clock after reset is released, whatever the load status. Once active, the block holds its mode until reset.

The controller has two states. ST_WAIT is the reset state: nothing is driven. ST_WAIT moves to ST_ACTIVE when the strap is high (transition T_STRAP) or when a load completes successfully (transition T_LOAD). ST_ACTIVE has no exit other than reset.

Top module: `pdi_mode_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pin_oe`, `pin_dir`, `sel_stb`, `status_code`, `sync_oe`, `ldone_oe` and `ldone_out` are all zero.
- R2: With `poc_strap` low, a rising clock edge that sees `cfg_done`=1 and `cfg_ok`=1 in ST_WAIT captures `cfg_code` into `status_code` and enters ST_ACTIVE, with outputs updated after that edge. A load with `cfg_ok`=0 changes nothing, and all pins stay disabled.
- R3: The strobe bit `sel_stb[k]` is the only one set for these codes: 4→bit0 (digital I/O), 5→bit1 (serial), 7→bit2 (bridge), 8→bit3 (16-bit async), 9→bit4 (8-bit async), 10→bit5 (16-bit sync), 11→bit6 (8-bit sync), 16..20→bit7 (fixed split), 128→bit8 (on-chip bus).
- R4: Codes 16, 17, 18, 19 and 20 put 32, 24, 16, 8 and 0 pins in input mode. The inputs are the lowest-numbered pins. The remaining upper pins have `pin_oe`=`pin_dir`=1, so code 17 gives 0xFF000000 and code 19 gives 0xFFFFFF00.
- R5: Code 0 and every code not listed in R3 give `sel_stb`=0, `pin_oe`=0 and `pin_dir`=0. In ST_ACTIVE, `sync_oe` is still 1.
- R6: `ldone_oe` and `ldone_out` are 0 until the first successful load. After the edge that sees it, both are 1 until reset, in either variant.
- R7: With `poc_strap` high, the first edge after reset release enters ST_ACTIVE with `status_code`=`poc_code`. `cfg_code` plays no part in the mode.
- R8: In ST_ACTIVE, later loads never change the mode: successful loads with other codes and failed loads are both ignored. Only reset returns the block to ST_WAIT.
- R9: In digital I/O mode, `pin_oe`=`pin_dir`=`dio_dir` (1 = output). In the serial, bridge, microcontroller and on-chip bus modes, `pin_oe` is all ones, handing the pads to the engine, and `pin_dir` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poc_strap | input | 1 | 1 = power-on-configured variant |
| poc_code | input | 8 | Select code used when the strap is high |
| cfg_done | input | 1 | Pulse: configuration load finished |
| cfg_ok | input | 1 | Load result, valid with `cfg_done` |
| cfg_code | input | 8 | Select code from the loaded configuration |
| dio_dir | input | 32 | Per-pin direction for digital I/O mode, 1 = output |
| status_code | output | 8 | Captured select code, 0 in ST_WAIT |
| sel_stb | output | 9 | One-hot protocol engine select |
| pin_oe | output | 32 | Per-pin output enable, 0 = high impedance |
| pin_dir | output | 32 | Per-pin fixed direction, 1 = output |
| sync_oe | output | 1 | Enable for the sync/latch drivers |
| ldone_oe | output | 1 | Enable for the load-done driver |
| ldone_out | output | 1 | Load-done level |

## Verification
On every cycle, the assertions check these properties:
- at most one strobe is set;
- no pin is enabled without a strobe;
- nothing is driven in the load-dependent variant before a successful load;
- both capture transitions, T_LOAD and T_STRAP, take the right code;
- ST_ACTIVE and the load-done driver are sticky.

Only the bench's scenarios show the rest, by comparing against a behavioural model on every clock: the exact strobe and pin masks for each listed code, the reserved codes, the digital I/O direction pass-through, and that failed or repeated loads are ignored.

// File: rtl/pdi_mode_pkg.sv
package pdi_mode_pkg;

    // Number of downstream protocol engine selects
    localparam int SEL_W = 9;

    typedef enum logic [3:0] {
        MD_OFF    = 4'd0,
        MD_DIO    = 4'd1,
        MD_SERIAL = 4'd2,
        MD_BRIDGE = 4'd3,
        MD_AS16   = 4'd4,
        MD_AS8    = 4'd5,
        MD_SY16   = 4'd6,
        MD_SY8    = 4'd7,
        MD_SPLIT  = 4'd8,
        MD_BUS    = 4'd9
    } pdi_mode_e;

    typedef enum logic {
        ST_WAIT   = 1'b0,
        ST_ACTIVE = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/pdi_code_decode.sv
module pdi_code_decode
    import pdi_mode_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    output pdi_mode_e         mode,
    output logic [2:0]        split_idx
);

    always_comb begin
        // codes 16..20 map to split steps 0..4 through the low bits
        split_idx = code[2:0];
        case (int'(code))
            4:                  mode = MD_DIO;
            5:                  mode = MD_SERIAL;
            7:                  mode = MD_BRIDGE;
            8:                  mode = MD_AS16;
            9:                  mode = MD_AS8;
            10:                 mode = MD_SY16;
            11:                 mode = MD_SY8;
            16, 17, 18, 19, 20: mode = MD_SPLIT;
            128:                mode = MD_BUS;
            default:            mode = MD_OFF;
        endcase
    end

endmodule

// File: rtl/pdi_pin_mask.sv
module pdi_pin_mask
    import pdi_mode_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  pdi_mode_e           mode,
    input  logic [2:0]          split_idx,
    input  logic [NUM_PINS-1:0] dio_dir,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_dir
);

    localparam int STEP = NUM_PINS / 4;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic split_out;
        // pin p is an output once the input count drops to p or below
        assign split_out = (p + int'(split_idx) * STEP) >= NUM_PINS;

        always_comb begin
            unique case (mode)
                MD_OFF: begin
                    pin_oe[p]  = 1'b0;
                    pin_dir[p] = 1'b0;
                end
                MD_DIO: begin
                    pin_oe[p]  = dio_dir[p];
                    pin_dir[p] = dio_dir[p];
                end
                MD_SPLIT: begin
                    pin_oe[p]  = split_out;
                    pin_dir[p] = split_out;
                end
                MD_SERIAL, MD_BRIDGE, MD_AS16, MD_AS8,
                MD_SY16, MD_SY8, MD_BUS: begin
                    pin_oe[p]  = 1'b1;
                    pin_dir[p] = 1'b0;
                end
                default: begin
                    pin_oe[p]  = 1'b0;
                    pin_dir[p] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pdi_mode_ctrl.sv
module pdi_mode_ctrl
    import pdi_mode_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int CODE_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                poc_strap,
    input  logic [CODE_W-1:0]   poc_code,
    input  logic                cfg_done,
    input  logic                cfg_ok,
    input  logic [CODE_W-1:0]   cfg_code,
    input  logic [NUM_PINS-1:0] dio_dir,
    output logic [CODE_W-1:0]   status_code,
    output logic [SEL_W-1:0]    sel_stb,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_dir,
    output logic                sync_oe,
    output logic                ldone_oe,
    output logic                ldone_out
);

    ctrl_state_e       state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic              loaded_q;
    logic              load_good;
    pdi_mode_e         dec_mode, mode_eff;
    logic [2:0]        split_idx;

    assign load_good = cfg_done & cfg_ok;

    // Next-state logic: T_STRAP has priority over T_LOAD
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_WAIT: begin
                if (poc_strap) begin
                    state_d = ST_ACTIVE;
                    code_d  = poc_code;
                end else if (load_good) begin
                    state_d = ST_ACTIVE;
                    code_d  = cfg_code;
                end
            end
            ST_ACTIVE: begin
                state_d = ST_ACTIVE;
            end
            default: begin
                state_d = ST_WAIT;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_WAIT;
            code_q   <= '0;
            loaded_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            code_q   <= code_d;
            loaded_q <= loaded_q | load_good;
        end
    end

    pdi_code_decode #(.CODE_W(CODE_W)) u_decode (
        .code      (code_q),
        .mode      (dec_mode),
        .split_idx (split_idx)
    );

    // Output process
    always_comb begin
        unique case (state_q)
            ST_ACTIVE: begin
                mode_eff = dec_mode;
                sync_oe  = 1'b1;
            end
            default: begin
                mode_eff = MD_OFF;
                sync_oe  = 1'b0;
            end
        endcase
        status_code = code_q;
        ldone_oe    = loaded_q;
        ldone_out   = loaded_q;
    end

    for (genvar s = 0; s < SEL_W; s++) begin : g_stb
        assign sel_stb[s] = (mode_eff == pdi_mode_e'(4'(s + 1)));
    end

    pdi_pin_mask #(.NUM_PINS(NUM_PINS)) u_mask (
        .mode      (mode_eff),
        .split_idx (split_idx),
        .dio_dir   (dio_dir),
        .pin_oe    (pin_oe),
        .pin_dir   (pin_dir)
    );

endmodule

// File: rtl/pdi_mode_ctrl_chk.sv
module pdi_mode_ctrl_chk
    import pdi_mode_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int CODE_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                poc_strap,
    input logic [CODE_W-1:0]   poc_code,
    input logic                cfg_done,
    input logic                cfg_ok,
    input logic [CODE_W-1:0]   cfg_code,
    input logic [NUM_PINS-1:0] dio_dir,
    input logic [CODE_W-1:0]   status_code,
    input logic [SEL_W-1:0]    sel_stb,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_dir,
    input logic                sync_oe,
    input logic                ldone_oe,
    input logic                ldone_out
);

    // R2: nothing driven before a good load in the load-dependent variant
    a_r2_held_until_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldone_oe && !poc_strap) |-> (pin_oe == '0 && !sync_oe && sel_stb == '0));

    // R2: T_LOAD captures the loaded code
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && cfg_ok && !sync_oe && !poc_strap)
            |=> (sync_oe && status_code == $past(cfg_code)));

    // R3: never more than one engine selected
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_stb));

    // R5: without a strobe no pin leaves high impedance
    a_r5_no_stb_no_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_stb == '0) |-> (pin_oe == '0 && pin_dir == '0));

    // R6: load-done driver turns on high after a good load and stays on
    a_r6_ldone_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && cfg_ok) |=> (ldone_oe && ldone_out));

    a_r6_ldone_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ldone_oe |=> ldone_oe);

    // R7: T_STRAP takes the strap code
    a_r7_strap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (poc_strap && !sync_oe) |=> (sync_oe && status_code == $past(poc_code)));

    // R8: the active mode holds until reset
    a_r8_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_oe |=> (sync_oe && $stable(status_code)));

endmodule

bind pdi_mode_ctrl pdi_mode_ctrl_chk #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/pdi_mode_ctrl_bench.sv
module pdi_mode_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poc_strap = 1'b0;
    logic [7:0]  poc_code = '0;
    logic        cfg_done = 1'b0;
    logic        cfg_ok = 1'b0;
    logic [7:0]  cfg_code = '0;
    logic [31:0] dio_dir = '0;
    logic [7:0]  status_code;
    logic [8:0]  sel_stb;
    logic [31:0] pin_oe;
    logic [31:0] pin_dir;
    logic        sync_oe;
    logic        ldone_oe;
    logic        ldone_out;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    bit       m_act;
    bit       m_loaded;
    int       m_code;

    always #5 clk = ~clk;

    pdi_mode_ctrl u_pdi_mode_ctrl (.*);

    function automatic logic [8:0] e_sel(int c, bit act);
        if (!act) return '0;
        case (c)
            4: return 9'd1;
            5: return 9'd2;
            7: return 9'd4;
            8: return 9'd8;
            9: return 9'd16;
            10: return 9'd32;
            11: return 9'd64;
            16, 17, 18, 19, 20: return 9'd128;
            128: return 9'd256;
            default: return '0;
        endcase
    endfunction

    function automatic logic [31:0] e_split(int c);
        case (c)
            17: return 32'hFF00_0000;
            18: return 32'hFFFF_0000;
            19: return 32'hFFFF_FF00;
            20: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] e_oe(int c, bit act, logic [31:0] dd);
        if (!act) return '0;
        case (c)
            4: return dd;
            5, 7, 8, 9, 10, 11, 128: return 32'hFFFF_FFFF;
            16, 17, 18, 19, 20: return e_split(c);
            default: return '0;
        endcase
    endfunction

    function automatic logic [31:0] e_dir(int c, bit act, logic [31:0] dd);
        if (!act) return '0;
        case (c)
            4: return dd;
            16, 17, 18, 19, 20: return e_split(c);
            default: return '0;
        endcase
    endfunction

    // reference model update
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act    <= 1'b0;
            m_loaded <= 1'b0;
            m_code   <= 0;
        end else begin
            if (cfg_done && cfg_ok) m_loaded <= 1'b1;
            if (!m_act && poc_strap) begin
                m_act  <= 1'b1;
                m_code <= int'(poc_code);
            end else if (!m_act && cfg_done && cfg_ok) begin
                m_act  <= 1'b1;
                m_code <= int'(cfg_code);
            end
        end
    end

    // compare on every clock, away from both edges
    always @(posedge clk) begin
        #3;
        if (!finished) begin
            logic [8:0]  xs;
            logic [31:0] xo;
            logic [31:0] xd;
            logic [7:0]  xc;
            xs = e_sel(m_code, m_act);
            xo = e_oe(m_code, m_act, dio_dir);
            xd = e_dir(m_code, m_act, dio_dir);
            xc = 8'(m_code);
            n_checks++;
            if (status_code !== xc || sel_stb !== xs || pin_oe !== xo ||
                pin_dir !== xd || sync_oe !== m_act ||
                ldone_oe !== m_loaded || ldone_out !== m_loaded) begin
                n_fail++;
                $display("FAIL %s: got code=%0d stb=%h oe=%h dir=%h sync=%b ld=%b/%b exp code=%0d stb=%h oe=%h dir=%h sync=%b ld=%b/%b",
                    cur_req, status_code, sel_stb, pin_oe, pin_dir, sync_oe,
                    ldone_oe, ldone_out, xc, xs, xo, xd, m_act, m_loaded, m_loaded);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(bit strap, logic [7:0] pc);
        @(negedge clk);
        rst_n     = 1'b0;
        poc_strap = strap;
        poc_code  = pc;
        cfg_done  = 1'b0;
        cfg_ok    = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic load(bit ok, logic [7:0] code);
        @(negedge clk);
        cfg_done = 1'b1;
        cfg_ok   = ok;
        cfg_code = code;
        @(negedge clk);
        cfg_done = 1'b0;
        cfg_ok   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int codes[$];
        cur_req = "R1";
        do_reset(1'b0, 8'd0);
        idle(3);

        // failed load leaves everything in high impedance
        cur_req = "R2";
        load(1'b0, 8'd5);
        idle(3);
        // good load into digital I/O with a direction mask
        cur_req = "R9";
        dio_dir = 32'hA5A5_0F0F;
        load(1'b1, 8'd4);
        idle(2);
        dio_dir = 32'h1234_5678;
        idle(2);
        // later loads ignored
        cur_req = "R8";
        load(1'b1, 8'd5);
        load(1'b0, 8'd16);
        idle(3);

        // every listed code plus reserved ones
        codes = '{0, 5, 7, 8, 9, 10, 11, 16, 17, 18, 19, 20, 128, 3, 6, 12, 21, 255};
        foreach (codes[i]) begin
            cur_req = "R6";
            do_reset(1'b0, 8'd0);
            idle(2);
            if (codes[i] >= 16 && codes[i] <= 20) cur_req = "R4";
            else if (codes[i] == 0 || codes[i] == 3 || codes[i] == 6 ||
                     codes[i] == 12 || codes[i] > 128 || codes[i] == 21) cur_req = "R5";
            else cur_req = "R3";
            load(1'b1, 8'(codes[i]));
            idle(3);
        end

        // power-on-configured variant
        cur_req = "R7";
        do_reset(1'b1, 8'd18);
        idle(3);
        cfg_code = 8'd5;
        load(1'b0, 8'd5);
        idle(2);
        cur_req = "R6";
        load(1'b1, 8'd9);
        idle(3);
        cur_req = "R7";
        do_reset(1'b1, 8'd128);
        idle(4);

        // reset returns to waiting
        cur_req = "R1";
        do_reset(1'b0, 8'd0);
        idle(3);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule